// File: doc/BRIEF.md
# Video sync mode detector

This block watches the raw horizontal and vertical sync inputs of a graphics video stream. It is meant for a multi-sync display front end, where a host uses the results to tell one input resolution from another. For each sync it works out which phase is the active pulse and so reports the polarity. It also raises a flag when that sync has stopped toggling, as happens in power-saving states or when nothing is plugged in. It reports the length of a line in reference-clock periods and the number of lines in a frame.

The block runs on the panel clock. A mode input sets how reference periods relate to it. In double-pixel mode every panel clock is one reference period. In single-pixel mode one reference period spans two panel clocks. The block compares all measured values against the values they held on the cycle before. Any difference latches an active-low interrupt, which stays asserted until the host pulses the clear input.

Top module: `sync_mode_detector`

## Requirements
- R1: `hs_pol` / `vs_pol` read 1 when the high phase of that sync is shorter than its low phase over a full period, and 0 otherwise. The value is decided at each rising edge, once a falling edge has been seen.
- R2: `hs_missing` / `vs_missing` go to 1 after 2^TO_LOG2 reference periods with no edge on that sync. They return to 0 on the cycle after the next edge.
- R3: `line_len` holds the number of reference periods between two consecutive active edges of the horizontal sync. The active edge is the falling edge when the polarity flag is 1 and the rising edge when it is 0. The value changes only at an active edge.
- R4: A reference period is one clock when `single_pix` = 0 and two clocks when `single_pix` = 1. With an even sync period of P clocks, `line_len` is therefore P in double mode and P/2 in single mode.
- R5: `frame_lines` holds the number of horizontal active edges between two consecutive vertical active edges. The value changes only at a vertical active edge.
- R6: When any of the two polarity flags, the two missing flags, `line_len` or `frame_lines` changes, `irq_n` goes to 0 and stays 0 until it is cleared.
- R7: A one-cycle pulse of `irq_clr` = 1 returns `irq_n` to 1 unless a change occurs in the same cycle; a change takes priority over the clear.
- R8: After a synchronous reset, all flags and counts read 0 and `irq_n` reads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Panel clock |
| rst | input | 1 | Synchronous reset, active high |
| hsync_pin | input | 1 | Raw horizontal sync, asynchronous |
| vsync_pin | input | 1 | Raw vertical sync, asynchronous |
| single_pix | input | 1 | 1: reference period is two clocks; 0: one clock |
| irq_clr | input | 1 | Interrupt clear strobe, active high |
| hs_pol | output | 1 | Horizontal sync polarity (1 = active high) |
| vs_pol | output | 1 | Vertical sync polarity (1 = active high) |
| hs_missing | output | 1 | Horizontal sync absent |
| vs_missing | output | 1 | Vertical sync absent |
| line_len | output | HCNT_W | Line length in reference periods |
| frame_lines | output | VCNT_W | Lines per frame |
| irq_n | output | 1 | Mode-change interrupt, active low |

## Verification
The bench drives sync pulses whose active phase is longer than the inactive one. A detector that trusts the generator's intended polarity, rather than comparing phase lengths, reports the wrong flag there. It keeps the frame shape fixed and flips only `single_pix`, so a design that ignores the mode or halves the count the wrong way shows an unchanged or doubled line length. It stops both syncs for longer than the timeout and then restarts them. A missing flag that never sets, or that sticks after edges return, is caught, and so is a line length that is overwritten while no edges arrive. It also lets the interrupt sit uncleared across several frames and then clears it in steady state, which exposes a design that releases the interrupt on its own or raises it again for no change.

// File: rtl/sdet_pkg.sv
package sdet_pkg;
  localparam int unsigned CH_H   = 0;
  localparam int unsigned CH_V   = 1;
  localparam int unsigned NUM_CH = 2;

  typedef struct packed {
    logic pol;
    logic absent;
  } chan_flags_t;
endpackage

// File: rtl/sdet_sync_chan.sv
module sdet_sync_chan
  import sdet_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned TO_LOG2     = 20,
  parameter int unsigned PW_W        = TO_LOG2 + 1
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        tick,
  input  logic        pin,
  output chan_flags_t flags,
  output logic        act_edge
);
  logic [SYNC_STAGES-1:0] shreg;
  logic                   lvl_d;
  logic                   lvl, rise, fall, edge_any;
  logic [PW_W-1:0]        hi_cnt, lo_cnt, hi_len, hi_nx, lo_nx, inc;
  logic                   seen_hi, pol_q, absent_q;
  logic [TO_LOG2-1:0]     to_cnt;

  assign lvl      = shreg[SYNC_STAGES-1];
  assign rise     = lvl & ~lvl_d;
  assign fall     = ~lvl & lvl_d;
  assign edge_any = rise | fall;
  assign inc      = {{(PW_W-1){1'b0}}, tick};
  assign hi_nx    = (hi_cnt == '1) ? hi_cnt : hi_cnt + inc;
  assign lo_nx    = (lo_cnt == '1) ? lo_cnt : lo_cnt + inc;

  // input synchronizer and edge history
  always_ff @(posedge clk) begin
    if (rst) begin
      shreg <= '0;
      lvl_d <= 1'b0;
    end else begin
      shreg <= {shreg[SYNC_STAGES-2:0], pin};
      lvl_d <= lvl;
    end
  end

  // phase length measurement and polarity decision
  always_ff @(posedge clk) begin
    if (rst) begin
      hi_cnt  <= '0;
      lo_cnt  <= '0;
      hi_len  <= '0;
      seen_hi <= 1'b0;
      pol_q   <= 1'b0;
    end else begin
      if (fall) begin
        hi_len  <= hi_nx;
        hi_cnt  <= '0;
        seen_hi <= 1'b1;
      end else if (lvl) begin
        hi_cnt <= hi_nx;
      end
      if (rise) begin
        if (seen_hi) pol_q <= (hi_len < lo_nx);
        lo_cnt <= '0;
      end else if (!lvl) begin
        lo_cnt <= lo_nx;
      end
    end
  end

  // absence timeout
  always_ff @(posedge clk) begin
    if (rst) begin
      to_cnt   <= '0;
      absent_q <= 1'b0;
    end else if (edge_any) begin
      to_cnt   <= '0;
      absent_q <= 1'b0;
    end else if (tick) begin
      if (to_cnt == '1) absent_q <= 1'b1;
      else              to_cnt   <= to_cnt + 1'b1;
    end
  end

  assign flags.pol    = pol_q;
  assign flags.absent = absent_q;
  assign act_edge     = pol_q ? fall : rise;

  a_r2_edge_clears_absent: assert property (@(posedge clk) disable iff (rst)
    edge_any |=> !flags.absent);
  a_r1_pol_only_on_rise: assert property (@(posedge clk) disable iff (rst)
    !rise |=> $stable(flags.pol));
endmodule

// File: rtl/sdet_line_meas.sv
module sdet_line_meas #(
  parameter int unsigned HCNT_W = 16,
  parameter int unsigned VCNT_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              h_act,
  input  logic              v_act,
  output logic [HCNT_W-1:0] h_len,
  output logic [VCNT_W-1:0] v_lines
);
  logic [HCNT_W-1:0] hcnt, hcnt_nx;
  logic [VCNT_W-1:0] lcnt, lcnt_nx;
  logic              h_armed, v_armed;

  assign hcnt_nx = (hcnt == '1) ? hcnt : hcnt + {{(HCNT_W-1){1'b0}}, tick};
  assign lcnt_nx = (lcnt == '1) ? lcnt : lcnt + {{(VCNT_W-1){1'b0}}, h_act};

  always_ff @(posedge clk) begin
    if (rst) begin
      hcnt    <= '0;
      h_len   <= '0;
      h_armed <= 1'b0;
    end else if (h_act) begin
      if (h_armed) h_len <= hcnt_nx;
      hcnt    <= '0;
      h_armed <= 1'b1;
    end else begin
      hcnt <= hcnt_nx;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lcnt    <= '0;
      v_lines <= '0;
      v_armed <= 1'b0;
    end else if (v_act) begin
      if (v_armed) v_lines <= lcnt_nx;
      lcnt    <= '0;
      v_armed <= 1'b1;
    end else begin
      lcnt <= lcnt_nx;
    end
  end

  a_r3_len_held_between_edges: assert property (@(posedge clk) disable iff (rst)
    !h_act |=> $stable(h_len));
  a_r5_lines_held_between_edges: assert property (@(posedge clk) disable iff (rst)
    !v_act |=> $stable(v_lines));
endmodule

// File: rtl/sdet_change_irq.sv
module sdet_change_irq #(
  parameter int unsigned STAT_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [STAT_W-1:0] stat,
  input  logic              clr,
  output logic              irq_n
);
  logic [STAT_W-1:0] prev;
  logic              chg;

  assign chg = (stat != prev);

  always_ff @(posedge clk) begin
    if (rst) begin
      prev  <= '0;
      irq_n <= 1'b1;
    end else begin
      prev <= stat;
      if (chg)      irq_n <= 1'b0;
      else if (clr) irq_n <= 1'b1;
    end
  end

  a_r6_change_asserts: assert property (@(posedge clk) disable iff (rst)
    chg |=> !irq_n);
  a_r6_stays_latched: assert property (@(posedge clk) disable iff (rst)
    (!irq_n && !clr) |=> !irq_n);
  a_r7_clear_releases: assert property (@(posedge clk) disable iff (rst)
    (clr && !chg) |=> irq_n);
endmodule

// File: rtl/sync_mode_detector.sv
module sync_mode_detector
  import sdet_pkg::*;
#(
  parameter int unsigned HCNT_W      = 16,
  parameter int unsigned VCNT_W      = 12,
  parameter int unsigned TO_LOG2     = 20,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hsync_pin,
  input  logic              vsync_pin,
  input  logic              single_pix,
  input  logic              irq_clr,
  output logic              hs_pol,
  output logic              vs_pol,
  output logic              hs_missing,
  output logic              vs_missing,
  output logic [HCNT_W-1:0] line_len,
  output logic [VCNT_W-1:0] frame_lines,
  output logic              irq_n
);
  localparam int unsigned STAT_W = 4 + HCNT_W + VCNT_W;

  logic              tick;
  logic [NUM_CH-1:0] pins, act;
  chan_flags_t       flg [NUM_CH];
  logic [STAT_W-1:0] stat;

  assign pins[CH_H] = hsync_pin;
  assign pins[CH_V] = vsync_pin;

  // reference period strobe
  always_ff @(posedge clk) begin
    if (rst)             tick <= 1'b0;
    else if (single_pix) tick <= ~tick;
    else                 tick <= 1'b1;
  end

  a_r4_single_alternates: assert property (@(posedge clk) disable iff (rst)
    (single_pix && tick) |=> !tick);
  a_r4_double_every_clock: assert property (@(posedge clk) disable iff (rst)
    !single_pix |=> tick);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    sdet_sync_chan #(
      .SYNC_STAGES(SYNC_STAGES),
      .TO_LOG2    (TO_LOG2)
    ) i_chan (
      .clk     (clk),
      .rst     (rst),
      .tick    (tick),
      .pin     (pins[c]),
      .flags   (flg[c]),
      .act_edge(act[c])
    );
  end

  sdet_line_meas #(
    .HCNT_W(HCNT_W),
    .VCNT_W(VCNT_W)
  ) i_meas (
    .clk    (clk),
    .rst    (rst),
    .tick   (tick),
    .h_act  (act[CH_H]),
    .v_act  (act[CH_V]),
    .h_len  (line_len),
    .v_lines(frame_lines)
  );

  assign hs_pol     = flg[CH_H].pol;
  assign vs_pol     = flg[CH_V].pol;
  assign hs_missing = flg[CH_H].absent;
  assign vs_missing = flg[CH_V].absent;
  assign stat       = {hs_pol, vs_pol, hs_missing, vs_missing, line_len, frame_lines};

  sdet_change_irq #(
    .STAT_W(STAT_W)
  ) i_irq (
    .clk  (clk),
    .rst  (rst),
    .stat (stat),
    .clr  (irq_clr),
    .irq_n(irq_n)
  );
endmodule

// File: tb/test_sync_mode_detector.sv
module test_sync_mode_detector;
  localparam int CLK_PERIOD = 10;
  localparam int HCNT_W = 16;
  localparam int VCNT_W = 12;
  localparam int TO_LOG2 = 12;
  localparam int NV = 6;
  // single, h period, h active width, h active level, lines, v active lines, v active level
  localparam int VEC [NV][7] = '{
    '{0, 32,  4, 1, 12, 2, 1},
    '{0, 40,  6, 0, 12, 2, 1},
    '{1, 40,  6, 0, 12, 2, 1},
    '{1, 36,  4, 1, 16, 3, 0},
    '{0, 24, 20, 0, 10, 8, 0},
    '{0, 28,  3, 1, 14, 1, 0}
  };

  logic clk = 0, rst = 1, hs = 0, vs = 0, single = 0, clr = 0;
  logic hs_pol, vs_pol, hs_miss, vs_miss, irq_n;
  logic [HCNT_W-1:0] line_len;
  logic [VCNT_W-1:0] frame_lines;

  int total = 0, bad = 0;
  int hp = 32, hw = 4, hpol = 1, vl = 12, vw = 2, vpol = 1;
  bit run_gen = 0;
  int pix = 0, line = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sync_mode_detector #(.HCNT_W(HCNT_W), .VCNT_W(VCNT_W), .TO_LOG2(TO_LOG2)) i_sync_mode_detector (
    .clk(clk), .rst(rst), .hsync_pin(hs), .vsync_pin(vs), .single_pix(single),
    .irq_clr(clr), .hs_pol(hs_pol), .vs_pol(vs_pol), .hs_missing(hs_miss),
    .vs_missing(vs_miss), .line_len(line_len), .frame_lines(frame_lines), .irq_n(irq_n)
  );

  // sync waveform generator, driven away from the active edge
  initial begin
    forever begin
      @(negedge clk);
      if (run_gen) begin
        pix = pix + 1;
        if (pix >= hp) begin
          pix = 0;
          line = (line + 1 >= vl) ? 0 : line + 1;
        end
        hs = (pix < hw) ? hpol[0] : ~hpol[0];
        vs = (line < vw) ? vpol[0] : ~vpol[0];
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic frames(input int n);
    repeat (n * hp * vl) @(negedge clk);
  endtask

  task automatic pulse_clr();
    @(negedge clk) clr = 1;
    @(negedge clk) clr = 0;
  endtask

  task automatic check_shape(input int sgl);
    int hi_h, hi_v;
    hi_h = hpol ? hw : hp - hw;
    hi_v = vpol ? vw : vl - vw;
    chk("R1 hs_pol", hs_pol, (2 * hi_h < hp) ? 1 : 0);
    chk("R1 vs_pol", vs_pol, (2 * hi_v < vl) ? 1 : 0);
    chk("R3/R4 line_len", line_len, sgl ? hp / 2 : hp);
    chk("R5 frame_lines", frame_lines, vl);
    chk("R2 hs_missing", hs_miss, 0);
    chk("R2 vs_missing", vs_miss, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog R6 actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R8 reset state
    chk("R8 hs_pol", hs_pol, 0);
    chk("R8 vs_pol", vs_pol, 0);
    chk("R8 missing", {hs_miss, vs_miss}, 0);
    chk("R8 line_len", line_len, 0);
    chk("R8 frame_lines", frame_lines, 0);
    chk("R8 irq_n", irq_n, 1);

    // table of sync shapes and modes
    run_gen = 1;
    for (int v = 0; v < NV; v++) begin
      single = VEC[v][0][0];
      hp = VEC[v][1]; hw = VEC[v][2]; hpol = VEC[v][3];
      vl = VEC[v][4]; vw = VEC[v][5]; vpol = VEC[v][6];
      frames(6);
      check_shape(VEC[v][0]);
      chk("R6 irq_n after change", irq_n, 0);
      pulse_clr();
      frames(2);
      chk("R7 irq_n after clear", irq_n, 1);
    end

    // R6 interrupt held without clear
    single = 0; hp = 30; hw = 3; hpol = 1; vl = 12; vw = 2; vpol = 1;
    frames(6);
    check_shape(0);
    chk("R6 irq_n low", irq_n, 0);
    frames(3);
    chk("R6 irq_n still low", irq_n, 0);
    pulse_clr();
    frames(2);
    chk("R7 irq_n released", irq_n, 1);

    // R2 absence: stop both syncs beyond the timeout
    run_gen = 0;
    repeat ((1 << TO_LOG2) + 300) @(negedge clk);
    chk("R2 hs_missing set", hs_miss, 1);
    chk("R2 vs_missing set", vs_miss, 1);
    chk("R6 irq_n on missing", irq_n, 0);
    chk("R3 line_len held", line_len, 30);
    pulse_clr();
    repeat (4) @(negedge clk);
    chk("R7 irq_n cleared while idle", irq_n, 1);
    run_gen = 1;
    frames(6);
    chk("R2 hs_missing cleared", hs_miss, 0);
    chk("R2 vs_missing cleared", vs_miss, 0);
    chk("R6 irq_n on return", irq_n, 0);
    chk("R3 line_len after return", line_len, 30);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule